// File: doc/BRIEF.md
# ADC Result Bank with Read-Clear Flags

This block keeps the most recent conversion result for each of eight scan slots. A converter-side write strobe loads a 12-bit sample into the slot named by an index. A register-side read port picks a slot and returns a 32-bit word. That word holds the sample, an extension field that follows the selected number format, and the slot's overrun and valid flags. The word is driven combinationally from the selected slot at all times. A read strobe on that port retires the slot: at the next clock edge both of the slot's flags drop to zero.

Each slot's flags are also driven as two 8-bit vectors, so a status word can mirror them: valid at bits 15:8 and overrun at bits 23:16. When transfers are enabled, every loaded result raises a one-cycle request toward a DMA engine. The block does not contain the analog converter, the channel sequencer or any bus protocol.

Top module: `adc_result_bank`

## Requirements
- R1: After synchronous active-low reset, every slot holds result 0 with valid and overrun clear, so the read word of every slot is 0, `valid_vec` and `ovr_vec` are 0, and `dma_req` is low.
- R2: A load (`ld_en` high at a clock edge) stores `ld_data` into slot `ld_slot`. From that edge on, bits 11:0 of `rd_data` show the stored value whenever `rd_slot` selects that slot.
- R3: A load sets the slot's valid flag, read word bit 17, at the clock edge of the load.
- R4: A load into a slot whose valid flag is already 1 sets its overrun flag (read word bit 16), and the flag stays set through further loads. A load into a slot whose valid flag is 0 leaves overrun at 0.
- R5: A cycle with `rd_en` high clears valid and overrun of the slot `rd_slot` at the next edge. The stored result and every other slot are left unchanged.
- R6: When a load and a read strobe hit the same slot in one cycle, the load wins: the new data is stored, valid becomes 1 and overrun becomes 0.
- R7: With `fmt_signed` = 0 (unsigned), read word bits 15:12 are 0.
- R8: With `fmt_signed` = 1 (two's complement), read word bits 15:12 are copies of result bit 11. Read word bits 31:18 are always 0.
- R9: `dma_req` is high for the one cycle after each edge at which a load happened with `dma_en` high. It is low after any edge without such a load.
- R10: Bit n of `valid_vec` and bit n of `ovr_vec` equal the valid and overrun flags of slot n.
- R11: Selecting a slot with `rd_en` low leaves its flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Result load strobe |
| ld_slot | input | 3 | Slot index for the load |
| ld_data | input | 12 | Result to store |
| fmt_signed | input | 1 | 0 = unsigned view, 1 = two's-complement view |
| dma_en | input | 1 | Enables DMA requests on loads |
| rd_en | input | 1 | Read strobe; clears the selected slot's flags |
| rd_slot | input | 3 | Slot selected for the read word |
| rd_data | output | 32 | Read word of the selected slot |
| valid_vec | output | 8 | Per-slot valid flags |
| ovr_vec | output | 8 | Per-slot overrun flags |
| dma_req | output | 1 | One-cycle DMA request per load |

## Verification
The hardest case to reach is a load and a read strobe landing on the same slot in the same cycle while that slot already holds an unread sample and a set overrun flag. In that case the load must win, and overrun must still drop to zero. The stimulus first loads the slot twice so that overrun is set, then drives `ld_en` and `rd_en` with equal indices for a single cycle. Afterwards it peeks at the slot with `rd_en` low, so that observing the result does not disturb it.

// File: rtl/adc_rb_pkg.sv
// Package: shared types of the ADC result bank.
// Assumes: nothing beyond standard SystemVerilog.
package adc_rb_pkg;

    // Per-slot update selected in one cycle
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_CLEAR   = 2'd1,
        ACT_LOAD    = 2'd2,
        ACT_LOAD_RD = 2'd3
    } slot_act_e;

    // Number format of the read view
    typedef enum logic {
        FMT_UNSIGNED = 1'b0,
        FMT_TWOS     = 1'b1
    } fmt_e;

endpackage

// File: rtl/adc_rb_slot.sv
// Module: one result slot with valid and overrun flags.
// Does: stores a sample on load. A load sets valid, and sets overrun when
//       valid was already set. A read clears both flags. When a load and a
//       read arrive together, the load is kept and overrun is cleared.
// Assumes: ld_hit and rd_hit are already decoded for this slot.
module adc_rb_slot #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_hit,
    input  logic             rd_hit,
    input  logic [RES_W-1:0] ld_data,
    output logic [RES_W-1:0] result,
    output logic             valid,
    output logic             ovr
);
    import adc_rb_pkg::*;

    slot_act_e act;

    // Purpose: choose this cycle's update from the two strobes
    always_comb begin
        unique case ({ld_hit, rd_hit})
            2'b10:   act = ACT_LOAD;
            2'b11:   act = ACT_LOAD_RD;
            2'b01:   act = ACT_CLEAR;
            default: act = ACT_HOLD;
        endcase
    end

    // Purpose: update the stored sample and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            case (act)
                ACT_LOAD: begin
                    result <= ld_data;
                    valid  <= 1'b1;
                    ovr    <= ovr | valid;
                end
                ACT_LOAD_RD: begin
                    result <= ld_data;
                    valid  <= 1'b1;
                    ovr    <= 1'b0;
                end
                ACT_CLEAR: begin
                    valid  <= 1'b0;
                    ovr    <= 1'b0;
                end
                default: begin
                    result <= result;
                end
            endcase
        end
    end

endmodule

// File: rtl/adc_rb_view.sv
// Module: read-word formatter for the result bank.
// Does: selects one slot and builds the read word. The sample goes in the
//       low bits, then the format extension, then overrun, then valid.
//       Every bit above those is zero.
// Assumes: WORD_W >= VIEW_W + 2 and VIEW_W > RES_W.
module adc_rb_view #(
    parameter int NUM_SLOTS = 8,
    parameter int RES_W     = 12,
    parameter int VIEW_W    = 16,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 3
) (
    input  logic [NUM_SLOTS-1:0][RES_W-1:0] results,
    input  logic [NUM_SLOTS-1:0]            valids,
    input  logic [NUM_SLOTS-1:0]            ovrs,
    input  logic [IDX_W-1:0]                sel,
    input  logic                            fmt_signed,
    output logic [WORD_W-1:0]               word
);
    import adc_rb_pkg::*;

    localparam int EXT_W = VIEW_W - RES_W;

    logic [RES_W-1:0] res_sel;
    logic             vld_sel;
    logic             ovr_sel;
    logic [EXT_W-1:0] ext;

    // Purpose: pick the selected slot, forcing zeros for an index past the bank
    always_comb begin
        res_sel = '0;
        vld_sel = 1'b0;
        ovr_sel = 1'b0;
        if (int'(sel) < NUM_SLOTS) begin
            res_sel = results[sel];
            vld_sel = valids[sel];
            ovr_sel = ovrs[sel];
        end
    end

    // Purpose: build the extension bits from the format control
    always_comb begin
        if (fmt_e'(fmt_signed) == FMT_TWOS) begin
            ext = {EXT_W{res_sel[RES_W-1]}};
        end else begin
            ext = '0;
        end
    end

    // Purpose: assemble the read word
    always_comb begin
        word                   = '0;
        word[RES_W-1:0]        = res_sel;
        word[VIEW_W-1:RES_W]   = ext;
        word[VIEW_W]           = ovr_sel;
        word[VIEW_W+1]         = vld_sel;
    end

endmodule

// File: rtl/adc_rb_dma.sv
// Module: DMA request strobe.
// Does: raises the request for one cycle after each load made while
//       transfers are enabled.
// Assumes: one load per cycle at most.
module adc_rb_dma (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_en,
    input  logic dma_en,
    output logic dma_req
);
    // Purpose: register the gated load strobe as the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req <= 1'b0;
        end else begin
            dma_req <= ld_en & dma_en;
        end
    end

endmodule

// File: rtl/adc_result_bank.sv
// Module: ADC result bank, the top of the block.
// Does: holds NUM_SLOTS samples with their valid and overrun flags. It
//       gives a combinational read word for the selected slot and clears
//       that slot's flags on a read strobe. It mirrors the flags as
//       vectors and pulses a DMA request on each load.
// Assumes: synchronous active-low reset. Only one load and one read are
//          presented per cycle.
module adc_result_bank #(
    parameter int NUM_SLOTS = 8,
    parameter int RES_W     = 12,
    parameter int VIEW_W    = 16,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [IDX_W-1:0]     ld_slot,
    input  logic [RES_W-1:0]     ld_data,
    input  logic                 fmt_signed,
    input  logic                 dma_en,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     rd_slot,
    output logic [WORD_W-1:0]    rd_data,
    output logic [NUM_SLOTS-1:0] valid_vec,
    output logic [NUM_SLOTS-1:0] ovr_vec,
    output logic                 dma_req
);

    logic [NUM_SLOTS-1:0][RES_W-1:0] results;

    // One storage cell per slot, with its own strobe decode
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic ld_hit;
        logic rd_hit;

        // Purpose: decode the load and read strobes for slot i
        always_comb begin
            ld_hit = ld_en && (ld_slot == IDX_W'(i));
            rd_hit = rd_en && (rd_slot == IDX_W'(i));
        end

        adc_rb_slot #(
            .RES_W (RES_W)
        ) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_hit  (ld_hit),
            .rd_hit  (rd_hit),
            .ld_data (ld_data),
            .result  (results[i]),
            .valid   (valid_vec[i]),
            .ovr     (ovr_vec[i])
        );
    end

    adc_rb_view #(
        .NUM_SLOTS (NUM_SLOTS),
        .RES_W     (RES_W),
        .VIEW_W    (VIEW_W),
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W)
    ) view_i (
        .results    (results),
        .valids     (valid_vec),
        .ovrs       (ovr_vec),
        .sel        (rd_slot),
        .fmt_signed (fmt_signed),
        .word       (rd_data)
    );

    adc_rb_dma dma_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .dma_en  (dma_en),
        .dma_req (dma_req)
    );

endmodule

// File: rtl/adc_result_bank_chk.sv
// Module: assertion checker for the ADC result bank, bound to the top.
// Does: checks flag updates, the read word format and the DMA pulse
//       against port behaviour.
// Assumes: attached through the bind statement at the end of this file.
module adc_result_bank_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int RES_W     = 12,
    parameter int VIEW_W    = 16,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ld_en,
    input logic [IDX_W-1:0]     ld_slot,
    input logic                 fmt_signed,
    input logic                 dma_en,
    input logic                 rd_en,
    input logic [IDX_W-1:0]     rd_slot,
    input logic [WORD_W-1:0]    rd_data,
    input logic [NUM_SLOTS-1:0] valid_vec,
    input logic [NUM_SLOTS-1:0] ovr_vec,
    input logic                 dma_req
);
    localparam int EXT_W = VIEW_W - RES_W;

    AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> valid_vec[$past(ld_slot)]); // R3

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(ld_en && ld_slot == rd_slot))
        |=> (!valid_vec[$past(rd_slot)] && !ovr_vec[$past(rd_slot)])); // R5

    AST_OVR_ON_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && valid_vec[ld_slot] && !(rd_en && rd_slot == ld_slot))
        |=> ovr_vec[$past(ld_slot)]); // R4

    AST_COLLIDE_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && rd_en && ld_slot == rd_slot)
        |=> (valid_vec[$past(ld_slot)] && !ovr_vec[$past(ld_slot)])); // R6

    AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_vec & ~valid_vec) == '0); // R4

    AST_EXT_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_signed |-> rd_data[VIEW_W-1:RES_W] == '0); // R7

    AST_EXT_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_signed |-> rd_data[VIEW_W-1:RES_W] == {EXT_W{rd_data[RES_W-1]}}); // R8

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WORD_W-1:VIEW_W+2] == '0); // R8

    AST_DMA_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && dma_en) |=> dma_req); // R9

    AST_DMA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en && dma_en) |=> !dma_req); // R9

    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !ld_en) |=> ($stable(valid_vec) && $stable(ovr_vec))); // R11

endmodule

bind adc_result_bank adc_result_bank_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .RES_W     (RES_W),
    .VIEW_W    (VIEW_W),
    .WORD_W    (WORD_W),
    .IDX_W     (IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .ld_slot    (ld_slot),
    .fmt_signed (fmt_signed),
    .dma_en     (dma_en),
    .rd_en      (rd_en),
    .rd_slot    (rd_slot),
    .rd_data    (rd_data),
    .valid_vec  (valid_vec),
    .ovr_vec    (ovr_vec),
    .dma_req    (dma_req)
);

// File: tb/adc_result_bank_tb_top.sv
// Bench: directed tests for the ADC result bank. Each task runs one
//        scenario and checks its own results.
// Assumes: 125 MHz clock. Inputs change 1 ns after a rising edge and are
//          sampled there.
module adc_result_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_slot = '0;
    logic [11:0] ld_data = '0;
    logic        fmt_signed = 1'b0;
    logic        dma_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_slot = '0;
    logic [31:0] rd_data;
    logic [7:0]  valid_vec;
    logic [7:0]  ovr_vec;
    logic        dma_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    adc_result_bank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .ld_slot    (ld_slot),
        .ld_data    (ld_data),
        .fmt_signed (fmt_signed),
        .dma_en     (dma_en),
        .rd_en      (rd_en),
        .rd_slot    (rd_slot),
        .rd_data    (rd_data),
        .valid_vec  (valid_vec),
        .ovr_vec    (ovr_vec),
        .dma_req    (dma_req)
    );

    // Purpose: watchdog that ends a hung run as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic v, input logic o,
                                            input logic [11:0] r, input logic s);
        logic [31:0] w;
        w = 32'h0;
        w[11:0]  = r;
        w[15:12] = s ? {4{r[11]}} : 4'h0;
        w[16]    = o;
        w[17]    = v;
        return w;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [2:0] s, input logic [11:0] d);
        ld_en = 1'b1; ld_slot = s; ld_data = d;
        step();
        ld_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] s, output logic [31:0] w);
        rd_en = 1'b0; rd_slot = s;
        #1;
        w = rd_data;
    endtask

    task automatic rd_strobe(input logic [2:0] s, output logic [31:0] w);
        rd_en = 1'b1; rd_slot = s;
        #1;
        w = rd_data;
        step();
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] w;
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 valid_vec", {24'h0, valid_vec}, 32'h0);
        chk("R1 ovr_vec", {24'h0, ovr_vec}, 32'h0);
        chk("R1 dma_req", {31'h0, dma_req}, 32'h0);
        peek(3'd3, w);
        chk("R1 slot3 word", w, 32'h0);
    endtask

    task automatic t_load_basic();
        logic [31:0] w;
        fmt_signed = 1'b0;
        load(3'd2, 12'h5A3);
        peek(3'd2, w);
        chk("R2 R3 slot2 word", w, word_of(1'b1, 1'b0, 12'h5A3, 1'b0));
        chk("R10 valid_vec", {24'h0, valid_vec}, 32'h04);
        load(3'd5, 12'h0F1);
        chk("R10 valid_vec two", {24'h0, valid_vec}, 32'h24);
        repeat (3) step();
        peek(3'd2, w);
        chk("R11 peek keeps", w, word_of(1'b1, 1'b0, 12'h5A3, 1'b0));
    endtask

    task automatic t_read_clear();
        logic [31:0] w;
        rd_strobe(3'd2, w);
        chk("R5 word during read", w, word_of(1'b1, 1'b0, 12'h5A3, 1'b0));
        peek(3'd2, w);
        chk("R5 cleared keeps data", w, word_of(1'b0, 1'b0, 12'h5A3, 1'b0));
        chk("R5 other slot kept", {24'h0, valid_vec}, 32'h20);
        rd_strobe(3'd5, w);
        chk("R5 all clear", {24'h0, valid_vec}, 32'h0);
    endtask

    task automatic t_overrun();
        logic [31:0] w;
        load(3'd1, 12'h111);
        chk("R4 no ovr first", {24'h0, ovr_vec}, 32'h0);
        load(3'd1, 12'h222);
        peek(3'd1, w);
        chk("R4 ovr set", w, word_of(1'b1, 1'b1, 12'h222, 1'b0));
        load(3'd1, 12'h333);
        chk("R4 R10 ovr sticks", {24'h0, ovr_vec}, 32'h02);
        load(3'd6, 12'h066);
        chk("R4 fresh slot no ovr", {24'h0, ovr_vec}, 32'h02);
        rd_strobe(3'd1, w);
        chk("R5 ovr read word", w, word_of(1'b1, 1'b1, 12'h333, 1'b0));
        chk("R5 ovr cleared", {24'h0, ovr_vec}, 32'h0);
        rd_strobe(3'd6, w);
    endtask

    task automatic t_collision();
        logic [31:0] w;
        load(3'd4, 12'h100);
        load(3'd4, 12'h200);
        chk("R6 precondition ovr", {24'h0, ovr_vec}, 32'h10);
        ld_en = 1'b1; ld_slot = 3'd4; ld_data = 12'hABC;
        rd_en = 1'b1; rd_slot = 3'd4;
        step();
        ld_en = 1'b0; rd_en = 1'b0;
        peek(3'd4, w);
        chk("R6 load wins", w, word_of(1'b1, 1'b0, 12'hABC, 1'b0));
        rd_strobe(3'd4, w);
    endtask

    task automatic t_format();
        logic [31:0] w;
        load(3'd0, 12'h8F0);
        fmt_signed = 1'b0;
        peek(3'd0, w);
        chk("R7 unsigned ext", w, 32'h000208F0);
        fmt_signed = 1'b1;
        peek(3'd0, w);
        chk("R8 signed ext", w, 32'h0002F8F0);
        load(3'd7, 12'h7FF);
        peek(3'd7, w);
        chk("R8 signed positive", w, 32'h000207FF);
        fmt_signed = 1'b0;
        rd_strobe(3'd0, w);
        rd_strobe(3'd7, w);
    endtask

    task automatic t_dma();
        dma_en = 1'b1;
        load(3'd3, 12'h033);
        chk("R9 pulse after load", {31'h0, dma_req}, 32'h1);
        step();
        chk("R9 pulse ends", {31'h0, dma_req}, 32'h0);
        load(3'd3, 12'h034);
        load(3'd3, 12'h035);
        chk("R9 back to back", {31'h0, dma_req}, 32'h1);
        dma_en = 1'b0;
        load(3'd2, 12'h022);
        chk("R9 disabled", {31'h0, dma_req}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_load_basic();
        t_read_clear();
        t_overrun();
        t_collision();
        t_format();
        t_dma();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule